// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block maps a handheld console's 16-bit CPU address space onto a large cartridge ROM of up to 2 MB and a battery-backed RAM of up to 32 KB. It has no storage of its own apart from four small control registers. A CPU write that lands in the ROM window (0x0000–0x7FFF) does not reach the ROM. Instead, it updates one of the four registers, and bits 14:13 of the address select which one. CPU reads in the ROM window leave the block as a 21-bit ROM address. Accesses in the external RAM window (0xA000–0xBFFF) leave as a 15-bit RAM address with a chip select and a write enable.

Two static inputs give the ROM and RAM sizes. The ROM size sets how many bits of the switchable bank number are kept. For the two largest ROMs, it also decides whether the 2-bit secondary register supplies the upper bank bits. A single mode flag chooses whether the secondary register also banks the fixed low ROM window and the 32 KB RAM. All address translation is combinational. Register updates take effect at the clock edge that ends the write cycle.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000–0x1FFF enables RAM access when cpu_wdata[3:0] is 0xA. Any other low nibble disables it.
- R2: A write to 0x2000–0x3FFF loads the 5-bit primary bank register from cpu_wdata[4:0] after masking by R3. If the masked value is 0, the register loads 1.
- R3: The primary bank mask depends on rom_size_code (0..7 = 2, 4, 8, 16, 32, 64 or 128 banks, with 7 treated like 32). Codes 0, 1, 2 and 3 keep 1, 2, 3 and 4 bits. Codes 4 to 7 keep 5 bits.
- R4: A write to 0x4000–0x5FFF loads the 2-bit secondary register from cpu_wdata[1:0]. With no register write, all registers hold their values.
- R5: A write to 0x6000–0x7FFF loads the mode flag from cpu_wdata[0].
- R6: For 0x4000–0x7FFF, rom_addr is bank × 0x4000 + (addr − 0x4000). The bank is the primary register, plus secondary bit 0 at bit 5 when the code is 5 (64 banks), or plus both secondary bits at bits 6:5 when the code is 6 (128 banks). During a register-write cycle, rom_addr still uses the pre-write register values.
- R7: For 0x0000–0x3FFF, rom_addr is bank × 0x4000 + addr. The bank is 0 in mode 0. In mode 1 it is secondary × 32 for code 6, (secondary bit 0) × 32 for code 5, and 0 for all other codes.
- R8: ram_addr is the address minus 0xA000, taken modulo 2048 for ram_size_code 1 (2 KB) and modulo 8192 for code 2 (8 KB). For code 3 (32 KB), the modulo-8192 offset has secondary × 0x2000 added in mode 1 only.
- R9: In the RAM window, cpu_rdata_ext is ram_rdata while RAM is enabled and 0xFF otherwise. While RAM is disabled or ram_size_code is 0, ram_cs and ram_we stay low, so writes are ignored.
- R10: After reset, RAM is disabled, the primary bank is 1, and the secondary register and mode flag are 0.
- R11: rom_cs is high exactly for 0x0000–0x7FFF. ram_cs is never high outside 0xA000–0xBFFF, and cpu_rdata_ext is 0xFF there. ram_we is ram_cs gated by cpu_wr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_size_code | input | 3 | Static ROM size code (R3) |
| ram_size_code | input | 2 | Static RAM size code (R8) |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_cs | output | 1 | ROM window select |
| rom_addr | output | 21 | Translated ROM byte address |
| ram_rdata | input | 8 | Read data from the external RAM |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | Translated RAM byte address |
| cpu_rdata_ext | output | 8 | Read data returned to the CPU for the RAM window |

## Verification
A control-register write and the ROM address translation happen in the same cycle, because the write address lies inside the ROM window. The same holds for a RAM write and the enable state that gates it. The bench issues writes at random addresses across the whole ROM window. During each write cycle it checks rom_addr and ram_we against its model as it stood before the write. It then probes after the clock edge to confirm that the new register value has taken effect. Random probes are mixed with directed cases for the zero-to-one substitution and for the upper-bit substitution on 64- and 128-bank ROMs, and every combination of ROM and RAM size is run.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_AW   = 16;
  localparam int CPU_DW   = 8;
  localparam int LO_W     = 5;
  localparam int SEC_W    = 2;
  localparam int BANK_W   = LO_W + SEC_W;
  localparam int OFF_W    = 14;
  localparam int ROM_AW   = BANK_W + OFF_W;
  localparam int RAM_OFF_W = 13;
  localparam int RAM_AW   = RAM_OFF_W + SEC_W;
  localparam int NUM_CTL  = 4;
  localparam logic [3:0] ENABLE_KEY = 4'hA;

  localparam int SEL_RAM_EN  = 0;
  localparam int SEL_BANK_LO = 1;
  localparam int SEL_SEC     = 2;
  localparam int SEL_MODE    = 3;

  typedef enum logic [2:0] {
    ROM_2B, ROM_4B, ROM_8B, ROM_16B, ROM_32B, ROM_64B, ROM_128B, ROM_RSV
  } rom_size_e;

  typedef enum logic [1:0] {
    RAM_NONE, RAM_2K, RAM_8K, RAM_32K
  } ram_size_e;

  typedef struct packed {
    logic             ram_en;
    logic [LO_W-1:0]  bank_lo;
    logic [SEC_W-1:0] sec;
    logic             mode;
  } cbc_regs_t;

  localparam cbc_regs_t RESET_REGS = '{ram_en: 1'b0, bank_lo: LO_W'(1),
                                       sec: '0, mode: 1'b0};

  // Bits of the primary bank kept for each ROM size.
  function automatic logic [LO_W-1:0] lo_mask(rom_size_e c);
    case (c)
      ROM_2B:  return LO_W'(5'h01);
      ROM_4B:  return LO_W'(5'h03);
      ROM_8B:  return LO_W'(5'h07);
      ROM_16B: return LO_W'(5'h0F);
      default: return '1;
    endcase
  endfunction

  // Value loaded into the primary bank register on a write.
  function automatic logic [LO_W-1:0] next_bank_lo(logic [CPU_DW-1:0] d, rom_size_e c);
    logic [LO_W-1:0] m;
    m = d[LO_W-1:0] & lo_mask(c);
    return (m == '0) ? LO_W'(1) : m;
  endfunction

  // Bank used for the switchable upper half of the ROM window.
  function automatic logic [BANK_W-1:0] upper_bank(logic [LO_W-1:0] lo,
                                                   logic [SEC_W-1:0] sec,
                                                   rom_size_e c);
    case (c)
      ROM_64B:  return {1'b0, sec[0], lo};
      ROM_128B: return {sec, lo};
      default:  return {{SEC_W{1'b0}}, lo};
    endcase
  endfunction

  // Bank used for the fixed lower half of the ROM window.
  function automatic logic [BANK_W-1:0] lower_bank(logic [SEC_W-1:0] sec,
                                                   logic mode, rom_size_e c);
    if (!mode) return '0;
    case (c)
      ROM_64B:  return {1'b0, sec[0], {LO_W{1'b0}}};
      ROM_128B: return {sec, {LO_W{1'b0}}};
      default:  return '0;
    endcase
  endfunction

  // Byte index into the external RAM.
  function automatic logic [RAM_AW-1:0] ram_index(logic [RAM_OFF_W-1:0] off,
                                                  logic [SEC_W-1:0] sec,
                                                  logic mode, ram_size_e c);
    case (c)
      RAM_2K:  return {{(RAM_AW-11){1'b0}}, off[10:0]};
      RAM_8K:  return {{SEC_W{1'b0}}, off};
      RAM_32K: return mode ? {sec, off} : {{SEC_W{1'b0}}, off};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int NSEL = NUM_CTL
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  output logic          rom_win,
  output logic          ram_win,
  output logic [NSEL-1:0] ctl_sel
);
  localparam int SW = $clog2(NSEL);
  logic ctl_wr;

  assign rom_win = ~cpu_addr[AW-1];
  assign ram_win = (cpu_addr[AW-1 -: 3] == 3'b101);
  assign ctl_wr  = cpu_wr & rom_win;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign ctl_sel[g] = ctl_wr && (cpu_addr[AW-2 -: SW] == SW'(g));
  end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int DW = CPU_DW,
  parameter int NSEL = NUM_CTL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEL-1:0] ctl_sel,
  input  logic [DW-1:0]   wdata,
  input  rom_size_e       rom_size,
  output cbc_regs_t       q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RESET_REGS;
    end else begin
      if (ctl_sel[SEL_RAM_EN])  q.ram_en  <= (wdata[3:0] == ENABLE_KEY);
      if (ctl_sel[SEL_BANK_LO]) q.bank_lo <= next_bank_lo(wdata, rom_size);
      if (ctl_sel[SEL_SEC])     q.sec     <= wdata[SEC_W-1:0];
      if (ctl_sel[SEL_MODE])    q.mode    <= wdata[0];
    end
  end
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
  import cbc_pkg::*;
#(
  parameter int OW = OFF_W,
  parameter int BW = BANK_W
) (
  input  logic [OW:0]    addr,
  input  cbc_regs_t      regs,
  input  rom_size_e      rom_size,
  output logic [BW+OW-1:0] rom_addr
);
  logic          hi_half;
  logic [BW-1:0] bank;

  assign hi_half  = addr[OW];
  assign bank     = hi_half ? upper_bank(regs.bank_lo, regs.sec, rom_size)
                            : lower_bank(regs.sec, regs.mode, rom_size);
  assign rom_addr = {bank, addr[OW-1:0]};
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
  import cbc_pkg::*;
#(
  parameter int DW = CPU_DW,
  parameter int OW = RAM_OFF_W,
  parameter int AW = RAM_AW
) (
  input  logic [OW-1:0] off,
  input  logic          ram_win,
  input  logic          cpu_wr,
  input  cbc_regs_t     regs,
  input  ram_size_e     ram_size,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_cs,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] rdata_out
);
  assign ram_cs    = ram_win & regs.ram_en & (ram_size != RAM_NONE);
  assign ram_we    = ram_cs & cpu_wr;
  assign ram_addr  = ram_index(off, regs.sec, regs.mode, ram_size);
  assign rdata_out = ram_cs ? ram_rdata : '1;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int DW  = CPU_DW,
  parameter int RAW = ROM_AW,
  parameter int SAW = RAM_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     rom_size_code,
  input  logic [1:0]     ram_size_code,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  input  logic           cpu_wr,
  output logic           rom_cs,
  output logic [RAW-1:0] rom_addr,
  input  logic [DW-1:0]  ram_rdata,
  output logic           ram_cs,
  output logic           ram_we,
  output logic [SAW-1:0] ram_addr,
  output logic [DW-1:0]  cpu_rdata_ext
);
  rom_size_e            rom_size;
  ram_size_e            ram_size;
  logic                 ram_win;
  logic [NUM_CTL-1:0]   ctl_sel;
  cbc_regs_t            regs_q;

  assign rom_size = rom_size_e'(rom_size_code);
  assign ram_size = ram_size_e'(ram_size_code);

  cbc_decode #(.AW(AW), .NSEL(NUM_CTL)) u_decode (
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .rom_win  (rom_cs),
    .ram_win  (ram_win),
    .ctl_sel  (ctl_sel)
  );

  cbc_regs #(.DW(DW), .NSEL(NUM_CTL)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_sel  (ctl_sel),
    .wdata    (cpu_wdata),
    .rom_size (rom_size),
    .q        (regs_q)
  );

  cbc_rom_map #(.OW(OFF_W), .BW(BANK_W)) u_rom_map (
    .addr     (cpu_addr[OFF_W:0]),
    .regs     (regs_q),
    .rom_size (rom_size),
    .rom_addr (rom_addr)
  );

  cbc_ram_map #(.DW(DW), .OW(RAM_OFF_W), .AW(SAW)) u_ram_map (
    .off       (cpu_addr[RAM_OFF_W-1:0]),
    .ram_win   (ram_win),
    .cpu_wr    (cpu_wr),
    .regs      (regs_q),
    .ram_size  (ram_size),
    .ram_rdata (ram_rdata),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .rdata_out (cpu_rdata_ext)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic [CPU_DW-1:0]  cpu_wdata,
  input logic               cpu_wr,
  input rom_size_e          rom_size,
  input logic [NUM_CTL-1:0] ctl_sel,
  input cbc_regs_t          regs_q,
  input logic [ROM_AW-1:0]  rom_addr,
  input logic               ram_cs,
  input logic               ram_we,
  input logic [CPU_DW-1:0]  cpu_rdata_ext
);
  p_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000) |=>
      (regs_q.ram_en == ($past(cpu_wdata[3:0]) == 4'hA)));

  p_bank_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q.bank_lo != '0);

  p_bank_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q.bank_lo & ~lo_mask(rom_size)) == '0);

  p_sec_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b010) |=>
      regs_q.sec == $past(cpu_wdata[1:0]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(regs_q));

  p_mode_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> regs_q.mode == $past(cpu_wdata[0]));

  p_low_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00 && !regs_q.mode) |-> rom_addr[ROM_AW-1:OFF_W] == '0);

  p_ram_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q.ram_en |-> (!ram_cs && !ram_we && cpu_rdata_ext == 8'hFF));

  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_sel));

  p_ram_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> cpu_addr[15:13] == 3'b101);
endmodule

bind cart_bank_ctrl cbc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_addr      (cpu_addr),
  .cpu_wdata     (cpu_wdata),
  .cpu_wr        (cpu_wr),
  .rom_size      (rom_size),
  .ctl_sel       (ctl_sel),
  .regs_q        (regs_q),
  .rom_addr      (rom_addr),
  .ram_cs        (ram_cs),
  .ram_we        (ram_we),
  .cpu_rdata_ext (cpu_rdata_ext)
);

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rom_size_code = 3'd0;
  logic [1:0]  ram_size_code = 2'd0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_wr = 1'b0;
  logic        rom_cs;
  logic [20:0] rom_addr;
  logic [7:0]  ram_rdata;
  logic        ram_cs;
  logic        ram_we;
  logic [14:0] ram_addr;
  logic [7:0]  cpu_rdata_ext;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state
  bit m_en;
  int m_lo, m_sec;
  bit m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM data stand-in: a pattern derived from the address it is given.
  assign ram_rdata = ram_addr[7:0] ^ {1'b0, ram_addr[14:8]};

  cart_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rom_size_code(rom_size_code),
    .ram_size_code(ram_size_code), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_rdata(ram_rdata),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .cpu_rdata_ext(cpu_rdata_ext)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kept_bits();
    return (rom_size_code >= 3'd4) ? 5 : int'(rom_size_code) + 1;
  endfunction

  function automatic int upper_extra();
    if (rom_size_code == 3'd5) return 32 * (m_sec % 2);
    if (rom_size_code == 3'd6) return 32 * m_sec;
    return 0;
  endfunction

  function automatic int exp_rom(int a);
    if (a < 16384) return (m_mode ? upper_extra() : 0) * 16384 + a;
    return (m_lo + upper_extra()) * 16384 + (a - 16384);
  endfunction

  function automatic bit exp_cs(int a);
    return (a >= 'hA000) && (a < 'hC000) && m_en && (ram_size_code != 2'd0);
  endfunction

  function automatic int exp_ram(int a);
    int off;
    off = (a - 'hA000) % 8192;
    case (ram_size_code)
      2'd1: return off % 2048;
      2'd2: return off;
      2'd3: return m_mode ? m_sec * 8192 + off : off;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_rdata(int a);
    int ra;
    if (!exp_cs(a)) return 255;
    ra = exp_ram(a);
    return (ra % 256) ^ (ra / 256);
  endfunction

  task automatic probe(int a);
    @(negedge clk);
    cpu_addr = 16'(a);
    cpu_wr = 1'b0;
    #1;
    check("R11 rom_cs", 32'(rom_cs), 32'(a < 'h8000));
    if (a < 'h4000) check("R7 rom_addr low window", 32'(rom_addr), 32'(exp_rom(a)));
    else if (a < 'h8000) check("R6 rom_addr switchable", 32'(rom_addr), 32'(exp_rom(a)));
    check("R9 ram_cs", 32'(ram_cs), 32'(exp_cs(a)));
    if (exp_cs(a)) check("R8 ram_addr", 32'(ram_addr), 32'(exp_ram(a)));
    check("R9 cpu_rdata_ext", 32'(cpu_rdata_ext), 32'(exp_rdata(a)));
    check("R11 ram_we idle", 32'(ram_we), 32'd0);
  endtask

  task automatic write(int a, int d);
    int m;
    @(negedge clk);
    cpu_addr = 16'(a);
    cpu_wdata = 8'(d);
    cpu_wr = 1'b1;
    #1;
    // Same-cycle collision: translation still uses pre-write registers.
    if (a < 'h8000) check("R6 rom_addr during write", 32'(rom_addr), 32'(exp_rom(a)));
    check("R9 ram_we", 32'(ram_we), 32'(exp_cs(a)));
    @(posedge clk);
    #1;
    cpu_wr = 1'b0;
    if (a < 'h2000) m_en = ((d % 16) == 10);
    else if (a < 'h4000) begin
      m = (d % 32) % (1 << kept_bits());
      m_lo = (m == 0) ? 1 : m;
    end
    else if (a < 'h6000) m_sec = d % 4;
    else if (a < 'h8000) m_mode = d[0];
  endtask

  task automatic do_reset(int rc, int mc);
    @(negedge clk);
    rst_n = 1'b0;
    cpu_wr = 1'b0;
    rom_size_code = 3'(rc);
    ram_size_code = 2'(mc);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_en = 0; m_lo = 1; m_sec = 0; m_mode = 0;
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h00C0FFEE);
    // R10: reset state
    do_reset(6, 3);
    @(negedge clk); cpu_addr = 16'h4000; #1;
    check("R10 reset bank 1", 32'(rom_addr), 32'h4000);
    cpu_addr = 16'h0123; #1;
    check("R10 reset low bank 0", 32'(rom_addr), 32'h0123);
    cpu_addr = 16'hA000; #1;
    check("R10 reset RAM disabled", 32'(cpu_rdata_ext), 32'hFF);
    check("R10 reset ram_cs low", 32'(ram_cs), 32'd0);

    // R2/R3: zero substitution after masking on a 4-bank ROM
    do_reset(1, 2);
    write('h2000, 'h04);
    probe('h4000);
    check("R2 masked zero becomes 1", 32'(rom_addr), 32'h4000);
    write('h3FFF, 'h07);
    probe('h4001);
    check("R3 4-bank mask", 32'(rom_addr), 32'(3 * 16384 + 1));

    // R6/R7: 128-bank upper bits, low window in mode 1
    do_reset(6, 3);
    write('h4000, 'hFB);
    write('h2000, 'h1F);
    probe('h7FFF);
    check("R6 128-bank top", 32'(rom_addr), 32'h1FFFFF);
    probe('h0000);
    check("R7 mode0 low bank", 32'(rom_addr), 32'h0);
    write('h6000, 'h01);
    probe('h0010);
    check("R7 mode1 low bank", 32'(rom_addr), 32'h180010);
    write('h6000, 'h00);
    write('h6000, 'h01);
    // R1/R8: enable with 0x1A, 32 KB RAM banked by secondary
    write('h0000, 'h1A);
    write('h4000, 'h02);
    write('hA123, 'h55);
    probe('hA123);
    check("R8 32K bank 2", 32'(ram_addr), 32'(2 * 8192 + 'h123));
    write('h1FFF, 'hA0);
    probe('hA123);
    check("R1 0xA0 disables", 32'(cpu_rdata_ext), 32'hFF);

    // R6: 64-bank uses only secondary bit 0
    do_reset(5, 1);
    write('h4000, 'h03);
    write('h2000, 'h01);
    probe('h4000);
    check("R6 64-bank bit5", 32'(rom_addr), 32'(33 * 16384));

    // Random sweep over all size combinations
    for (int rc = 0; rc < 8; rc++) begin
      for (int mc = 0; mc < 4; mc++) begin
        do_reset(rc, mc);
        for (int n = 0; n < 150; n++) begin
          int r, a;
          r = int'($urandom % 5);
          case (r)
            0: write(int'($urandom % 32768), int'($urandom % 256));
            1: write('hA000 + int'($urandom % 8192), int'($urandom % 256));
            2: probe(int'($urandom % 32768));
            3: probe('hA000 + int'($urandom % 8192));
            default: begin
              a = int'($urandom % 65536);
              probe(a);
            end
          endcase
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule